// File: doc/BRIEF.md
# Microprocessor Bus Register Slave

This block lets an external microprocessor read and write an on-chip byte store over an asynchronous, Intel-style bus with a ready handshake. The master selects the chip with an active-low select. It presents an address while the latch-enable input is high, and then pulses either the read strobe or the write strobe. Every control input is brought into the system clock domain through a two-flop synchronizer, and strobe edges are detected there.

A read asks the internal store for the byte at the latched address. That store answers after a programmable number of clock cycles, from 1 to 8. The slave holds ready low until the answer sits in an output holding register, and then raises it. A write drops ready briefly. The byte on the data pins is committed to the latched address when the write strobe rises.

The bidirectional data bus is presented as separate input, output and output-enable pins, and the pad ring combines them into one bus. The output enable follows the raw select and read strobe, so the bus is released as soon as either one goes inactive.

Top module: `mpb_slave`

## Requirements
- R1: After reset, ready is high, the output enable is low, and every byte of the store reads 0x00.
- R2: While select is low and latch-enable is high, the address pins are copied into the address latch. After latch-enable falls, later changes on the address pins have no effect on which location is accessed.
- R3: bus_oe is high only while cs_n is low, rd_n is low and mode_sel is low. It drops in the same cycle that any of them goes inactive.
- R4: Ready is low by the third rising clock edge after rd_n falls.
- R5: With L = lat_sel + 1, ready rises on exactly the (4+L)-th rising edge after rd_n falls, for every L from 1 to 8.
- R6: When ready rises during a read, bus_dout carries the byte stored at the latched address. Addresses at or above the store depth (32 by default, so any address with a bit set above bit 4) read 0x00, and writes to them change nothing.
- R7: A write drives ready low on the third rising edge after wr_n falls and high again on the fourth. The byte on bus_din when the rising wr_n is seen is stored at the latched address.
- R8: If cs_n goes high during a cycle, the cycle is abandoned. An abandoned write stores nothing. An abandoned read releases the bus, ready returns high, and the next read returns correct data.
- R9: With mode_sel high, the slave does not respond: ready stays high, the bus is never driven, and writes store nothing.
- R10: With cs_n high, strobes are ignored: nothing is stored, the bus is not driven and ready stays high.
- R11: Whenever no cycle is in progress, ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Bus style select, low for Intel-style operation |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch enable; address is transparent while high |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 15 | Address bus |
| lat_sel | input | 3 | Store read latency minus one |
| bus_din | input | 8 | Data bus, inbound half |
| bus_dout | output | 8 | Data bus, outbound half |
| bus_oe | output | 1 | Data bus output enable |
| rdy | output | 1 | Ready; low while the current cycle is not complete |

## Verification
The hardest case to reach from the pins is a read abandoned while the store still has a response in flight, followed at once by a new read. Only then can a late, stale answer be mistaken for fresh data. The bench sets the longest latency, raises the select partway through the wait, and then issues another read to a different location with the shortest latency, checking the returned byte against its own model of the store. Ready timing is swept over all eight latency settings, and its rise is counted to the exact edge.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    localparam int ADDR_W_DEF = 15;
    localparam int DATA_W_DEF = 8;
    localparam int MEM_AW_DEF = 5;
    localparam int LAT_W_DEF  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_DRAIN,
        ST_WR_ACT,
        ST_WR_ACK
    } mpb_state_e;

endpackage

// File: rtl/mpb_sync.sv
module mpb_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/mpb_store.sv
module mpb_store #(
    parameter int ADDR_W = mpb_pkg::ADDR_W_DEF,
    parameter int DATA_W = mpb_pkg::DATA_W_DEF,
    parameter int MEM_AW = mpb_pkg::MEM_AW_DEF,
    parameter int LAT_W  = mpb_pkg::LAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LAT_W-1:0]  lat_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int DEPTH = 1 << MEM_AW;
    localparam int CNT_W = LAT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } port_s;

    port_s             port_d, port_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    logic wr_hit;
    logic rd_hit;

    assign wr_hit = (wr_addr[ADDR_W-1:MEM_AW] == '0);
    assign rd_hit = (port_q.addr[ADDR_W-1:MEM_AW] == '0);

    always_comb begin
        mem_d = mem_q;
        if (wr_en && wr_hit) begin
            mem_d[wr_addr[MEM_AW-1:0]] = wr_data;
        end

        port_d           = port_q;
        port_d.rsp_valid = 1'b0;
        if (req) begin
            port_d.cnt  = CNT_W'(lat_sel) + CNT_W'(1);
            port_d.addr = req_addr;
        end else if (port_q.cnt != '0) begin
            port_d.cnt = port_q.cnt - CNT_W'(1);
            if (port_q.cnt == CNT_W'(1)) begin
                port_d.rsp_valid = 1'b1;
                port_d.rsp_data  = rd_hit ? mem_q[port_q.addr[MEM_AW-1:0]] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            port_q <= port_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rsp_valid = port_q.rsp_valid;
    assign rsp_data  = port_q.rsp_data;

    // R5: a new request only arrives when nothing is in flight
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (port_q.cnt == '0));

    // R5: a response is produced only at the end of a countdown
    a_r5_rsp_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        port_q.rsp_valid |-> ($past(port_q.cnt) == CNT_W'(1)));

endmodule

// File: rtl/mpb_ctrl.sv
module mpb_ctrl #(
    parameter int ADDR_W = mpb_pkg::ADDR_W_DEF,
    parameter int DATA_W = mpb_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_s,
    input  logic              cs_s,
    input  logic              ale_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] din,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rdy,
    output logic [DATA_W-1:0] hold
);
    import mpb_pkg::*;

    typedef struct packed {
        mpb_state_e        state;
        logic              rdy;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] hold;
        logic              rd_p;
        logic              wr_p;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic active;
    logic rd_fall;
    logic wr_fall;

    assign active  = !mode_s && !cs_s;
    assign rd_fall = ctl_q.rd_p && !rd_s;
    assign wr_fall = ctl_q.wr_p && !wr_s;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rd_p = rd_s;
        ctl_d.wr_p = wr_s;
        req        = 1'b0;
        req_addr   = ctl_q.addr;
        wr_en      = 1'b0;
        wr_addr    = ctl_q.addr;
        wr_data    = din;

        if (ale_s && active) begin
            ctl_d.addr = addr_in;
        end

        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.rdy = 1'b1;
                if (active && rd_fall) begin
                    req         = 1'b1;
                    ctl_d.state = ST_RD_WAIT;
                    ctl_d.rdy   = 1'b0;
                end else if (active && wr_fall) begin
                    ctl_d.state = ST_WR_ACT;
                    ctl_d.rdy   = 1'b0;
                end
            end
            ST_RD_WAIT: begin
                if (!active || rd_s) begin
                    ctl_d.rdy   = 1'b1;
                    ctl_d.state = rsp_valid ? ST_IDLE : ST_DRAIN;
                end else if (rsp_valid) begin
                    ctl_d.hold  = rsp_data;
                    ctl_d.rdy   = 1'b1;
                    ctl_d.state = ST_RD_DONE;
                end
            end
            ST_RD_DONE: begin
                if (!active || rd_s) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                ctl_d.rdy = 1'b1;
                if (rsp_valid) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_WR_ACT: begin
                ctl_d.rdy = 1'b1;
                if (!active) begin
                    ctl_d.state = ST_IDLE;
                end else if (wr_s) begin
                    wr_en       = 1'b1;
                    ctl_d.state = ST_IDLE;
                end else begin
                    ctl_d.state = ST_WR_ACK;
                end
            end
            ST_WR_ACK: begin
                if (!active) begin
                    ctl_d.state = ST_IDLE;
                end else if (wr_s) begin
                    wr_en       = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.rdy   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.rdy   <= 1'b1;
            ctl_q.rd_p  <= 1'b1;
            ctl_q.wr_p  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdy  = ctl_q.rdy;
    assign hold = ctl_q.hold;

    // R4: a detected read strobe pulls ready low on the next edge
    a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE && active && rd_fall) |=> !rdy);

    // R5: ready rises in a read only after the store has answered
    a_r5_ready_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy) && ctl_q.state == ST_RD_DONE) |-> $past(rsp_valid));

    // R11: ready idles high
    a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) |-> rdy);

    // R8, R9: a commit needs a selected Intel-style cycle
    a_r8_commit_selected: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!cs_s && !mode_s));

    // R2: the latch holds while latch-enable is low
    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_s |=> $stable(ctl_q.addr));

endmodule

// File: rtl/mpb_slave.sv
module mpb_slave #(
    parameter int ADDR_W = mpb_pkg::ADDR_W_DEF,
    parameter int DATA_W = mpb_pkg::DATA_W_DEF,
    parameter int MEM_AW = mpb_pkg::MEM_AW_DEF,
    parameter int LAT_W  = mpb_pkg::LAT_W_DEF,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LAT_W-1:0]  lat_sel,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              rdy
);

    localparam int CTL_W = 5;

    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic              mode_s, cs_s, ale_s, rd_s, wr_s;
    logic              req, wr_en, rsp_valid;
    logic [ADDR_W-1:0] req_addr, wr_addr;
    logic [DATA_W-1:0] wr_data, rsp_data, hold;

    assign ctl_raw = {mode_sel, cs_n, ale, rd_n, wr_n};

    mpb_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_N),
        .RST_VAL (5'b01011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ctl_raw),
        .dout  (ctl_s)
    );

    assign {mode_s, cs_s, ale_s, rd_s, wr_s} = ctl_s;

    mpb_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_s    (mode_s),
        .cs_s      (cs_s),
        .ale_s     (ale_s),
        .rd_s      (rd_s),
        .wr_s      (wr_s),
        .addr_in   (addr),
        .din       (bus_din),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .req       (req),
        .req_addr  (req_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rdy       (rdy),
        .hold      (hold)
    );

    mpb_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MEM_AW (MEM_AW),
        .LAT_W  (LAT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_addr  (req_addr),
        .lat_sel   (lat_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign bus_oe   = !mode_sel && !cs_n && !rd_n;
    assign bus_dout = hold;

    // R3: the bus is never driven while deselected
    a_r3_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !(bus_oe && !cs_n && $past(cs_n) && cs_s));

    // R9: the other bus style never starts a write
    a_r9_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && $past(mode_s)) |-> rdy);

endmodule

// File: tb/tb_mpb_slave.sv
`timescale 1ns/1ps
module tb_mpb_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic        cs_n = 1'b1;
    logic        ale = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [14:0] addr = '0;
    logic [2:0]  lat_sel = '0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic        rdy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [32];

    always #2.5 clk = ~clk;

    mpb_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .cs_n     (cs_n),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .lat_sel  (lat_sel),
        .bus_din  (bus_din),
        .bus_dout (bus_dout),
        .bus_oe   (bus_oe),
        .rdy      (rdy)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latch_addr(logic [14:0] a);
        cs_n = 1'b0; ale = 1'b1; addr = a;
        tick(4);
        ale = 1'b0;
        tick(4);
        addr = ~a;   // R2: later address changes must not matter
        tick(1);
    endtask

    task automatic do_read(logic [14:0] a, int lat, logic [7:0] exp, string tag);
        int k = 0;
        lat_sel = 3'(lat - 1);
        latch_addr(a);
        chk(rdy == 1'b1, "R11", "ready before read", int'(rdy), 1);
        rd_n = 1'b0;
        while (k < 40) begin
            tick(1);
            k++;
            if (k == 3) chk(rdy == 1'b0, "R4", "ready low after strobe", int'(rdy), 0);
            if (k > 3 && rdy) break;
        end
        chk(k == 4 + lat, "R5", "edges until ready", k, 4 + lat);
        chk(bus_oe == 1'b1, "R3", "driving during read", int'(bus_oe), 1);
        chk(bus_dout == exp, tag, "read data", int'(bus_dout), int'(exp));
        rd_n = 1'b1;
        #1;
        chk(bus_oe == 1'b0, "R3", "released after strobe", int'(bus_oe), 0);
        tick(5);
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic do_write(logic [14:0] a, logic [7:0] d);
        latch_addr(a);
        bus_din = d;
        wr_n = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            tick(1);
            if (k == 3) chk(rdy == 1'b0, "R7", "ready low in write", int'(rdy), 0);
            if (k == 4) chk(rdy == 1'b1, "R7", "ready high in write", int'(rdy), 1);
        end
        wr_n = 1'b1;
        tick(5);
        cs_n = 1'b1;
        tick(2);
        if (a[14:5] == '0) exp_mem[a[4:0]] = d;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state
        chk(rdy == 1'b1, "R1", "ready after reset", int'(rdy), 1);
        chk(bus_oe == 1'b0, "R1", "bus idle after reset", int'(bus_oe), 0);

        // R5 / R1: latency sweep over reset contents
        for (int l = 1; l <= 8; l++) do_read(15'(l), l, 8'h00, "R1");

        // R7: fill the store
        for (int a = 0; a < 32; a++) do_write(15'(a), 8'((a * 37 + 11) & 8'hFF));

        // R6 / R2: read back with varying latency
        for (int a = 0; a < 32; a++) do_read(15'(a), (a % 8) + 1, exp_mem[a], "R6");

        // R6: out-of-range write and read, no aliasing
        do_write(15'h0040, 8'hAA);
        do_read(15'h0040, 1, 8'h00, "R6");
        do_read(15'h0000, 2, exp_mem[0], "R6");

        // R8: abandoned read with a response still in flight
        lat_sel = 3'd7;
        latch_addr(15'd3);
        rd_n = 1'b0;
        tick(6);
        cs_n = 1'b1;
        #1;
        chk(bus_oe == 1'b0, "R3", "release on deselect", int'(bus_oe), 0);
        tick(4);
        chk(rdy == 1'b1, "R8", "ready after read abort", int'(rdy), 1);
        rd_n = 1'b1;
        do_read(15'd9, 1, exp_mem[9], "R8");
        tick(20);
        do_read(15'd10, 1, exp_mem[10], "R8");

        // R8: abandoned write stores nothing
        latch_addr(15'd5);
        bus_din = 8'hEE;
        wr_n = 1'b0;
        tick(6);
        cs_n = 1'b1;
        tick(4);
        chk(rdy == 1'b1, "R8", "ready after write abort", int'(rdy), 1);
        wr_n = 1'b1;
        tick(5);
        do_read(15'd5, 3, exp_mem[5], "R8");

        // R9: other bus style selected
        mode_sel = 1'b1;
        tick(4);
        cs_n = 1'b0; ale = 1'b1; addr = 15'd2;
        tick(4);
        ale = 1'b0;
        tick(2);
        bus_din = 8'h77;
        wr_n = 1'b0;
        tick(3);
        chk(rdy == 1'b1, "R9", "ready in write, other mode", int'(rdy), 1);
        wr_n = 1'b1;
        tick(4);
        rd_n = 1'b0;
        tick(8);
        chk(bus_oe == 1'b0, "R9", "no drive, other mode", int'(bus_oe), 0);
        chk(rdy == 1'b1, "R9", "ready in read, other mode", int'(rdy), 1);
        rd_n = 1'b1;
        cs_n = 1'b1;
        tick(2);
        mode_sel = 1'b0;
        tick(4);
        do_read(15'd2, 4, exp_mem[2], "R9");

        // R10: strobes while deselected
        cs_n = 1'b1;
        addr = 15'd7;
        bus_din = 8'h3C;
        wr_n = 1'b0;
        tick(5);
        chk(rdy == 1'b1, "R10", "ready, deselected write", int'(rdy), 1);
        wr_n = 1'b1;
        tick(5);
        rd_n = 1'b0;
        tick(6);
        chk(bus_oe == 1'b0, "R10", "no drive, deselected", int'(bus_oe), 0);
        chk(rdy == 1'b1, "R10", "ready, deselected read", int'(rdy), 1);
        rd_n = 1'b1;
        tick(4);
        do_read(15'd7, 5, exp_mem[7], "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule